// File: doc/BRIEF.md
# Byte-Masked OTP Page Access Controller

This block is a register-mapped front end for a one-time-programmable store organised as 128-bit pages. A host reaches it through a simple request/response register port. It loads four 32-bit data words and a 16-bit byte-enable mask, then writes a command word. That command write is itself the trigger: it either programs the data words into a page or reads a page back into the data words. Only the bytes whose enable bit is set are moved.

Each request is answered one cycle later with a response code. Registers are checked for access width, and the 16-bit and 32-bit registers are checked separately. An access of an illegal size takes priority over an access to an offset that maps to nothing. Completion of a page operation sets a sticky done flag. The flag is cleared by writing one to it, and it is also driven on a dedicated output. The page store is modelled as an internal array in which a page never programmed reads as zero.

Top module: `otp_page_ctrl`

## Requirements
- R1: After reset, CMD (offset 0x00) reads 0, BYTEEN (0x04) reads 0, FLAGS (0x08) reads 0, TIMING (0x0C) reads 0x00001485, WORD0..WORD3 (0x10, 0x14, 0x18, 0x1C) read 0, and `doneOut` is 0.
- R2: Every request with `reqValid` high is answered by `rspValid` high exactly one cycle later. A write with response code 0 updates the register, and a later read returns it: all 16 bits of BYTEEN and all 32 bits of TIMING and WORD0..WORD3 can be written. 16-bit registers read back in `rspRdata[15:0]` with zeros above.
- R3: `reqSize` encodes 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = reserved. CMD, BYTEEN and FLAGS accept only size 1, and TIMING and WORD0..WORD3 accept only size 2. Any other legal size at a mapped offset gives response code 1 and changes no state.
- R4: Size 0 or 3 gives response code 1 at any offset, including unmapped ones. With size 1 or 2, an offset that is misaligned (low two bits nonzero) or above 0x1C gives response code 2. Neither case changes any state.
- R5: A CMD write stores only the bits under mask 0x39FF, and CMD reads back that masked value. Bit 15 is not stored.
- R6: A CMD write with bit 15 clear reads page CMD[8:0] into the data words. Page byte i (0..15) lands in WORD(i/4) bits [8*(i%4)+7 : 8*(i%4)] only when BYTEEN[i] is 1. Data bytes whose enable bit is clear keep their value.
- R7: A CMD write with bit 15 set programs page CMD[8:0] from the data words, using the same byte placement and byte gating as R6. Page bytes whose enable bit is clear keep their value. A page that has never been programmed reads as all zeros.
- R8: The transfer and FLAGS bit 0 (done) take effect on the clock edge after the one that accepts the CMD write. `doneOut` equals FLAGS bit 0.
- R9: Writing FLAGS clears each bit written as 1 and keeps each bit written as 0. If a completion and a clear of done fall on the same edge, the completion wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Register request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte offset of the register |
| reqSize | input | 2 | Access size code (0 = 8, 1 = 16, 2 = 32, 3 = reserved) |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Response present, one cycle after the request |
| rspErr | output | 2 | 0 = ok, 1 = bad size, 2 = unmapped offset |
| rspRdata | output | 32 | Read data, zero on error or write |
| doneOut | output | 1 | High while the done flag is set |

## Verification
The bench builds the block with its default parameters: 512 pages and an 8-bit offset. This puts the top page 0x1FF within reach, and a command word of all ones tests the stored mask and the page field together. Offsets above 0x1C, misaligned offsets and all four size codes are also exercised, so both error codes and their priority are seen. Random masks over a small set of pages, plus the top page, make repeated partial programs and partial reads of the same page common, and these are compared with a byte-level model.

// File: rtl/otp_page_ctrl_pkg.sv
package otp_page_ctrl_pkg;

  // Access size codes on reqSize
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // Response codes on rspErr
  typedef enum logic [1:0] {
    RSP_OK       = 2'd0,
    RSP_BAD_SIZE = 2'd1,
    RSP_UNMAPPED = 2'd2
  } rspCode_e;

  // Register index = offset / 4
  typedef enum logic [2:0] {
    REG_CMD    = 3'd0,
    REG_BYTEEN = 3'd1,
    REG_FLAGS  = 3'd2,
    REG_TIMING = 3'd3,
    REG_WORD0  = 3'd4,
    REG_WORD1  = 3'd5,
    REG_WORD2  = 3'd6,
    REG_WORD3  = 3'd7
  } regIdx_e;

  localparam int NUM_REGS      = 8;
  localparam int NUM_HALF_REGS = 3;
  localparam int CMD_PROG_BIT  = 15;

  // Strobes from control to datapath
  typedef struct packed {
    logic       cmdWr;
    logic       benWr;
    logic       flagsWr;
    logic       timingWr;
    logic [3:0] wordWr;
    logic       rdEn;
    regIdx_e    rdIdx;
    logic       xferGo;
    logic       xferProg;
  } otpStrobes_t;

endpackage

// File: rtl/otp_page_ctrl_fsm.sv
module otp_page_ctrl_fsm
  import otp_page_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqProgBit,
  output otpStrobes_t       strobes,
  output logic              rspValid,
  output logic [1:0]        rspErr
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] regIdx;
  logic             aligned;
  logic             mapped;
  logic             halfReg;
  logic             sizeLegal;
  rspCode_e         code;
  logic             accept;
  logic             pendGo;
  logic             pendProg;

  assign regIdx    = reqAddr[ADDR_W-1:2];
  assign aligned   = (reqAddr[1:0] == 2'b00);
  assign mapped    = aligned && (regIdx < IDX_W'(NUM_REGS));
  assign halfReg   = (regIdx < IDX_W'(NUM_HALF_REGS));
  assign sizeLegal = (reqSize == SZ_HALF) || (reqSize == SZ_WORD);

  // Size errors outrank unmapped offsets
  always_comb begin
    if (!sizeLegal)
      code = RSP_BAD_SIZE;
    else if (!mapped)
      code = RSP_UNMAPPED;
    else if (halfReg && reqSize != SZ_HALF)
      code = RSP_BAD_SIZE;
    else if (!halfReg && reqSize != SZ_WORD)
      code = RSP_BAD_SIZE;
    else
      code = RSP_OK;
  end

  assign accept = reqValid && (code == RSP_OK);

  always_comb begin
    strobes          = '0;
    strobes.rdIdx    = regIdx_e'(regIdx[2:0]);
    strobes.rdEn     = accept && !reqWrite;
    strobes.xferGo   = pendGo;
    strobes.xferProg = pendProg;
    if (accept && reqWrite) begin
      unique case (regIdx_e'(regIdx[2:0]))
        REG_CMD:    strobes.cmdWr     = 1'b1;
        REG_BYTEEN: strobes.benWr     = 1'b1;
        REG_FLAGS:  strobes.flagsWr   = 1'b1;
        REG_TIMING: strobes.timingWr  = 1'b1;
        REG_WORD0:  strobes.wordWr[0] = 1'b1;
        REG_WORD1:  strobes.wordWr[1] = 1'b1;
        REG_WORD2:  strobes.wordWr[2] = 1'b1;
        REG_WORD3:  strobes.wordWr[3] = 1'b1;
        default:    ;
      endcase
    end
  end

  // Command bit is held on its own path; the transfer runs one edge later
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendGo   <= 1'b0;
      pendProg <= 1'b0;
      rspValid <= 1'b0;
      rspErr   <= RSP_OK;
    end else begin
      pendGo   <= accept && reqWrite && (regIdx_e'(regIdx[2:0]) == REG_CMD);
      pendProg <= reqProgBit;
      rspValid <= reqValid;
      rspErr   <= reqValid ? code : RSP_OK;
    end
  end

endmodule

// File: rtl/otp_page_ctrl_dpath.sv
module otp_page_ctrl_dpath
  import otp_page_ctrl_pkg::*;
#(
  parameter int          PAGES      = 512,
  parameter int          PAGE_BYTES = 16,
  parameter logic [15:0] CMD_KEEP   = 16'h39FF,
  parameter logic [31:0] TIMING_RST = 32'h0000_1485
) (
  input  logic        clk,
  input  logic        rstN,
  input  otpStrobes_t strobes,
  input  logic [31:0] wdata,
  output logic [31:0] rspRdata,
  output logic        doneOut
);

  localparam int PAGE_W     = $clog2(PAGES);
  localparam int PAGE_BITS  = PAGE_BYTES * 8;
  localparam int DATA_WORDS = PAGE_BYTES / 4;

  logic [15:0]           cmdReg;
  logic [PAGE_BYTES-1:0] benReg;
  logic [15:0]           flagsReg;
  logic [31:0]           timingReg;
  logic [31:0]           wordReg [DATA_WORDS];

  logic [PAGE_BITS-1:0]  pageMem [PAGES];
  logic [PAGES-1:0]      pageUsed;
  logic [PAGE_W-1:0]     pageSel;
  logic [PAGE_BITS-1:0]  pageNow;
  logic [PAGE_BITS-1:0]  dataVec;
  logic [PAGE_BITS-1:0]  progVec;
  logic                  xferRead;
  logic                  xferProg;
  logic [31:0]           rdMux;

  assign pageSel  = cmdReg[PAGE_W-1:0];
  assign pageNow  = pageUsed[pageSel] ? pageMem[pageSel] : '0;
  assign xferRead = strobes.xferGo && !strobes.xferProg;
  assign xferProg = strobes.xferGo && strobes.xferProg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg    <= '0;
      benReg    <= '0;
      timingReg <= TIMING_RST;
    end else begin
      if (strobes.cmdWr)    cmdReg    <= wdata[15:0] & CMD_KEEP;
      if (strobes.benWr)    benReg    <= wdata[PAGE_BYTES-1:0];
      if (strobes.timingWr) timingReg <= wdata;
    end
  end

  // Completion set beats a same-edge clear
  always_ff @(posedge clk) begin
    if (!rstN)
      flagsReg <= '0;
    else
      flagsReg <= (flagsReg & ~(strobes.flagsWr ? wdata[15:0] : 16'h0))
                | {15'h0, strobes.xferGo};
  end

  assign doneOut = flagsReg[0];

  // Per-byte data registers and program merge
  for (genvar w = 0; w < DATA_WORDS; w++) begin : g_word
    for (genvar b = 0; b < 4; b++) begin : g_byte
      localparam int BI = w * 4 + b;
      always_ff @(posedge clk) begin
        if (!rstN)
          wordReg[w][b*8 +: 8] <= 8'h00;
        else if (xferRead && benReg[BI])
          wordReg[w][b*8 +: 8] <= pageNow[BI*8 +: 8];
        else if (strobes.wordWr[w])
          wordReg[w][b*8 +: 8] <= wdata[b*8 +: 8];
      end
      assign dataVec[BI*8 +: 8] = wordReg[w][b*8 +: 8];
      assign progVec[BI*8 +: 8] = benReg[BI] ? dataVec[BI*8 +: 8]
                                             : pageNow[BI*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (xferProg) pageMem[pageSel] <= progVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      pageUsed <= '0;
    else if (xferProg)
      pageUsed[pageSel] <= 1'b1;
  end

  always_comb begin
    unique case (strobes.rdIdx)
      REG_CMD:    rdMux = {16'h0, cmdReg};
      REG_BYTEEN: rdMux = 32'(benReg);
      REG_FLAGS:  rdMux = {16'h0, flagsReg};
      REG_TIMING: rdMux = timingReg;
      REG_WORD0:  rdMux = wordReg[0];
      REG_WORD1:  rdMux = wordReg[1];
      REG_WORD2:  rdMux = wordReg[2];
      REG_WORD3:  rdMux = wordReg[3];
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      rspRdata <= '0;
    else
      rspRdata <= strobes.rdEn ? rdMux : 32'h0;
  end

endmodule

// File: rtl/otp_page_ctrl.sv
module otp_page_ctrl
  import otp_page_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGES  = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [31:0]       reqWdata,
  output logic              rspValid,
  output logic [1:0]        rspErr,
  output logic [31:0]       rspRdata,
  output logic              doneOut
);

  otpStrobes_t strobes;

  otp_page_ctrl_fsm #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqAddr    (reqAddr),
    .reqSize    (reqSize),
    .reqProgBit (reqWdata[CMD_PROG_BIT]),
    .strobes    (strobes),
    .rspValid   (rspValid),
    .rspErr     (rspErr)
  );

  otp_page_ctrl_dpath #(.PAGES(PAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wdata    (reqWdata),
    .rspRdata (rspRdata),
    .doneOut  (doneOut)
  );

endmodule

// File: rtl/otp_page_ctrl_chk.sv
module otp_page_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [1:0]        reqSize,
  input logic [31:0]       reqWdata,
  input logic              rspValid,
  input logic [1:0]        rspErr,
  input logic [31:0]       rspRdata,
  input logic              doneOut
);

  logic badSize;
  logic unmapped;
  logic cmdWrite;
  logic doneClear;

  assign badSize   = (reqSize == 2'd0) || (reqSize == 2'd3);
  assign unmapped  = (reqAddr[1:0] != 2'b00) || (reqAddr > ADDR_W'(8'h1C));
  assign cmdWrite  = reqValid && reqWrite && reqAddr == '0 && reqSize == 2'd1;
  assign doneClear = reqValid && reqWrite && reqAddr == ADDR_W'(8'h08)
                   && reqSize == 2'd1 && reqWdata[0];

  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  p_rsp_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  p_size_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && badSize) |=> (rspErr == 2'd1));

  p_unmapped_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !badSize && unmapped) |=> (rspErr == 2'd2));

  p_wide_on_half_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize == 2'd2 && reqAddr[1:0] == 2'b00 && reqAddr < ADDR_W'(8'h0C))
      |=> (rspErr == 2'd1));

  p_err_no_data_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr != 2'd0) |-> (rspRdata == 32'h0));

  p_done_after_cmd_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrite |=> ##1 doneOut);

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && !doneClear) |=> doneOut);

endmodule

bind otp_page_ctrl otp_page_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqWrite (reqWrite),
  .reqAddr  (reqAddr),
  .reqSize  (reqSize),
  .reqWdata (reqWdata),
  .rspValid (rspValid),
  .rspErr   (rspErr),
  .rspRdata (rspRdata),
  .doneOut  (doneOut)
);

// File: tb/otp_page_ctrl_test.sv
module otp_page_ctrl_test;

  localparam int ADDR_W = 8;
  localparam int PAGES  = 512;

  logic              clk = 1'b0;
  logic              rstN;
  logic              reqValid;
  logic              reqWrite;
  logic [ADDR_W-1:0] reqAddr;
  logic [1:0]        reqSize;
  logic [31:0]       reqWdata;
  logic              rspValid;
  logic [1:0]        rspErr;
  logic [31:0]       rspRdata;
  logic              doneOut;

  int checks = 0;
  int errors = 0;

  // Model state
  logic [127:0] mMem [PAGES];
  logic [127:0] mData;
  logic [15:0]  mBen;
  logic [15:0]  mCmd;
  logic [15:0]  mFlags;
  logic [31:0]  mTiming;

  always #5 clk = ~clk;

  otp_page_ctrl #(.ADDR_W(ADDR_W), .PAGES(PAGES)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata), .doneOut(doneOut)
  );

  function automatic logic [127:0] mergeBytes(input logic [127:0] dst,
                                              input logic [127:0] src,
                                              input logic [15:0] en);
    logic [127:0] r = dst;
    for (int i = 0; i < 16; i++)
      if (en[i]) r[i*8 +: 8] = src[i*8 +: 8];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [7:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output logic [1:0] er);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqSize = sz; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    if (rspValid !== 1'b1) begin
      checks++; errors++;
      $display("FAIL R2: actual rspValid %b expected 1", rspValid);
    end
    rd = rspRdata;
    er = rspErr;
  endtask

  task automatic wrOk(input string tag, input logic [7:0] a, input logic [1:0] sz,
                      input logic [31:0] wd);
    logic [31:0] rd; logic [1:0] er;
    access(1'b1, a, sz, wd, rd, er);
    check(tag, 32'(er), 32'd0);
  endtask

  task automatic rdCheck(input string tag, input logic [7:0] a, input logic [1:0] sz,
                         input logic [31:0] exp);
    logic [31:0] rd; logic [1:0] er;
    access(1'b0, a, sz, 32'h0, rd, er);
    check(tag, 32'(er), 32'd0);
    check(tag, rd, exp);
  endtask

  task automatic errCheck(input string tag, input bit wr, input logic [7:0] a,
                          input logic [1:0] sz, input logic [1:0] expErr);
    logic [31:0] rd; logic [1:0] er;
    access(wr, a, sz, 32'hFFFF_FFFF, rd, er);
    check(tag, 32'(er), 32'(expErr));
  endtask

  task automatic setWord(input int w, input logic [31:0] v);
    wrOk("R2", 8'(8'h10 + 4 * w), 2'd2, v);
    mData[w*32 +: 32] = v;
  endtask

  task automatic setBen(input logic [15:0] v);
    wrOk("R2", 8'h04, 2'd1, 32'(v));
    mBen = v;
  endtask

  task automatic command(input logic [15:0] val);
    logic [8:0] pg;
    wrOk("R5", 8'h00, 2'd1, 32'(val));
    mCmd = val & 16'h39FF;
    pg = val[8:0];
    if (val[15]) mMem[pg] = mergeBytes(mMem[pg], mData, mBen);
    else         mData    = mergeBytes(mData, mMem[pg], mBen);
    mFlags[0] = 1'b1;
    @(negedge clk);
    check("R8 doneOut", 32'(doneOut), 32'd1);
  endtask

  task automatic checkWords(input string tag);
    for (int w = 0; w < 4; w++)
      rdCheck(tag, 8'(8'h10 + 4 * w), 2'd2, mData[w*32 +: 32]);
  endtask

  task automatic clearDone();
    wrOk("R9", 8'h08, 2'd1, 32'h1);
    mFlags[0] = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int p = 0; p < PAGES; p++) mMem[p] = '0;
    mData = '0; mBen = '0; mCmd = '0; mFlags = '0; mTiming = 32'h1485;
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0;
    reqSize = '0; reqWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 doneOut", 32'(doneOut), 32'd0);
    rdCheck("R1 cmd", 8'h00, 2'd1, 32'h0);
    rdCheck("R1 byteen", 8'h04, 2'd1, 32'h0);
    rdCheck("R1 flags", 8'h08, 2'd1, 32'h0);
    rdCheck("R1 timing", 8'h0C, 2'd2, 32'h0000_1485);
    checkWords("R1 words");

    // R2 full-width writes
    wrOk("R2", 8'h0C, 2'd2, 32'hA5C3_0F69);
    rdCheck("R2 timing", 8'h0C, 2'd2, 32'hA5C3_0F69);
    setBen(16'hFFFF);
    rdCheck("R2 byteen", 8'h04, 2'd1, 32'h0000_FFFF);
    setWord(0, 32'h0302_0100); setWord(1, 32'h0706_0504);
    setWord(2, 32'h0B0A_0908); setWord(3, 32'h0F0E_0D0C);
    checkWords("R2 words");

    // R7 unprogrammed page reads zero; R6 full read
    command(16'd300);
    checkWords("R7 blank page");
    clearDone();
    check("R9 cleared", 32'(doneOut), 32'd0);

    // R5 mask, R7 program top page with all command bits set
    setWord(0, 32'h3322_1100); setWord(1, 32'h7766_5544);
    setWord(2, 32'hBBAA_9988); setWord(3, 32'hFFEE_DDCC);
    command(16'hFFFF);
    rdCheck("R5 cmd mask", 8'h00, 2'd1, 32'h0000_39FF);
    setBen(16'h00FF);
    setWord(0, 32'h0); setWord(1, 32'h0); setWord(2, 32'h0); setWord(3, 32'h0);
    command(16'h01FF);
    checkWords("R6 masked read top page");
    check("R6 byte order", mData[31:0], 32'h3322_1100);

    // R9 write-zero keeps done, write-one clears
    wrOk("R9", 8'h08, 2'd1, 32'h0);
    rdCheck("R9 keep", 8'h08, 2'd1, 32'h1);
    clearDone();
    rdCheck("R9 clear", 8'h08, 2'd1, 32'h0);

    // R3 / R4 error responses leave state alone
    errCheck("R3 wide cmd", 1'b1, 8'h00, 2'd2, 2'd1);
    errCheck("R3 wide byteen", 1'b1, 8'h04, 2'd2, 2'd1);
    errCheck("R3 half timing", 1'b1, 8'h0C, 2'd1, 2'd1);
    errCheck("R3 half word1", 1'b1, 8'h14, 2'd1, 2'd1);
    errCheck("R3 byte word2", 1'b1, 8'h18, 2'd0, 2'd1);
    errCheck("R4 size beats map", 1'b1, 8'h40, 2'd0, 2'd1);
    errCheck("R4 reserved size", 1'b0, 8'h21, 2'd3, 2'd1);
    errCheck("R4 above map", 1'b1, 8'h40, 2'd1, 2'd2);
    errCheck("R4 misaligned", 1'b1, 8'h12, 2'd2, 2'd2);
    errCheck("R4 just past", 1'b0, 8'h20, 2'd2, 2'd2);
    check("R3 no command", 32'(doneOut), 32'd0);
    rdCheck("R3 cmd kept", 8'h00, 2'd1, 32'(mCmd));
    rdCheck("R3 byteen kept", 8'h04, 2'd1, 32'(mBen));
    rdCheck("R3 timing kept", 8'h0C, 2'd2, 32'hA5C3_0F69);
    checkWords("R4 words kept");

    // Random mix of partial programs and reads
    for (int it = 0; it < 400; it++) begin
      int op = $urandom % 6;
      logic [8:0] pg = (($urandom % 8) == 0) ? 9'h1FF : 9'($urandom % 6);
      case (op)
        0: setBen(16'($urandom));
        1: setWord($urandom % 4, $urandom);
        2: command({1'b1, 6'(($urandom % 64) & 6'h39), pg});
        3: begin
             command({1'b0, 6'(($urandom % 64) & 6'h39), pg});
             checkWords("R6 random read");
           end
        4: begin
             rdCheck("R8 flags", 8'h08, 2'd1, 32'(mFlags));
             if ($urandom % 2) clearDone();
           end
        default: begin
             setBen(16'hFFFF);
             command({7'h00, pg});
             checkWords("R7 page image");
           end
      endcase
    end
    rdCheck("R5 last cmd", 8'h00, 2'd1, 32'(mCmd));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule